// File: doc/BRIEF.md
# On-Off-Keyed Frame Receiver with Bit Destuffing

This block recovers a short identifier from a serial on-off-keyed data line that has already been sliced into logic levels and sampled at the centre of each bit by an external bit-timing circuit. A high level on the line means the carrier is on (dominant) and a low level means it is off (recessive). At the nominal rate of one bit every 50 microseconds, the sample strobe pulses once per bit. The block ignores the line in every clock cycle without a strobe.

Before it accepts a frame, the receiver looks for a quiet bus. A frame is then a dominant run and a recessive run of fixed length, followed by one dominant start bit. After the start bit come 16 payload bits, with stuff bits inserted so that no level lasts too long. The receiver removes the stuff bits and gathers the payload. It accepts the frame only when the second byte is the exact inverse of the first. An accepted frame updates the ID output and raises a one-clock valid pulse. A broken stuffing rule or a failed inverse check raises a one-clock error pulse.

Top module: `ook_frame_rx`

## Requirements
- R1: After reset, `id_out` is 0x00 and neither `id_valid` nor `frame_err` is high.
- R2: The receiver does not accept a frame until it has seen at least 6 consecutive recessive (0) sampled bits. Any dominant bit seen before that count is reached clears the count. A frame sent after only 5 quiet bits produces no pulse.
- R3: Once the receiver is armed, it expects exactly 5 dominant (1) bits, then exactly 5 recessive (0) bits, then one dominant start bit. If either run is shorter or longer, the receiver returns to quiet search with its count cleared, and the frame produces no pulse.
- R4: The payload is 16 destuffed bits, with a dominant level read as 1. The first byte arrives MSB first and is the ID; the second byte arrives MSB first and must equal its bitwise inverse. On success, `id_out` takes the first byte and `id_valid` is high for exactly one clock, in the cycle after the clock edge that samples the 16th payload bit.
- R5: The start bit opens a dominant run of length 1. Once a run reaches 4 equal bits, the next sampled bit is a stuff bit. The stuff bit is discarded and begins a new run of length 1 at its own level. Stuff bits count toward runs like any other bit.
- R6: If a stuff position holds the same level as the run it follows, `frame_err` pulses for one clock, no ID is produced, and the receiver returns to quiet search with its count cleared.
- R7: If the second byte is not the inverse of the first, `frame_err` pulses for one clock, `id_valid` stays low and `id_out` keeps its previous value.
- R8: `id_out` changes only when `id_valid` pulses, and it holds its value across ignored and rejected frames.
- R9: The line is sampled only in cycles where `bit_stb` is high. Line changes between strobes have no effect, and no pulse follows a cycle without a strobe.
- R10: When a frame completes (accepted or rejected), the receiver returns to quiet search with its count cleared. A new frame needs a fresh run of at least 6 recessive bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Sliced data line, 1 = carrier on (dominant) |
| bit_stb | input | 1 | One-cycle strobe at each bit centre |
| id_out | output | ID_W | Last accepted ID, held between frames |
| id_valid | output | 1 | One-clock pulse when a frame is accepted |
| frame_err | output | 1 | One-clock pulse on a stuffing or inverse-check failure |

## Verification
A receiver that arms too early or too late, or that miscounts a preamble run, shows up at the ports as a valid pulse that should not happen or one that is missing, and this appears within the same frame. A run counter that drifts by one mistakes a data bit for a stuff bit. This shows up as a misplaced error pulse at the next stuff position, or as a shifted ID at the end of the payload. The frames the bench sends are chosen to drive long runs at both levels, so stuff bits fall at several payload offsets. Noise between strobes exposes any sampling outside the strobe in the pulse that follows.

// File: rtl/ook_rx_pkg.sv
package ook_rx_pkg;

    typedef enum logic [1:0] {
        S_QUIET = 2'd0,
        S_PDOM  = 2'd1,
        S_PREC  = 2'd2,
        S_DATA  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/ook_destuff.sv
module ook_destuff #(
    parameter int RUN_MAX = 4,
    localparam int LW = $clog2(RUN_MAX + 1)
) (
    input  logic          run_pol,
    input  logic [LW-1:0] run_len,
    input  logic          bit_in,
    output logic          is_stuff,
    output logic          stuff_bad,
    output logic          nxt_pol,
    output logic [LW-1:0] nxt_len
);

    localparam logic [LW-1:0] RUN_LIM = LW'(RUN_MAX);
    localparam logic [LW-1:0] ONE     = LW'(1);

    always_comb begin
        is_stuff  = (run_len == RUN_LIM);
        stuff_bad = is_stuff && (bit_in == run_pol);
        if (!is_stuff && (bit_in == run_pol)) begin
            nxt_pol = run_pol;
            nxt_len = run_len + ONE;
        end else begin
            nxt_pol = bit_in;
            nxt_len = ONE;
        end
    end

endmodule

// File: rtl/ook_inv_check.sv
module ook_inv_check #(
    parameter int ID_W = 8
) (
    input  logic [2*ID_W-1:0] word,
    output logic              match,
    output logic [ID_W-1:0]   id_part
);

    always_comb begin
        id_part = word[2*ID_W-1:ID_W];
        match   = (word[2*ID_W-1:ID_W] == ~word[ID_W-1:0]);
    end

endmodule

// File: rtl/ook_frame_rx.sv
module ook_frame_rx
    import ook_rx_pkg::*;
#(
    parameter int ID_W      = 8,
    parameter int IDLE_BITS = 6,
    parameter int PRE_BITS  = 5,
    parameter int RUN_MAX   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_line,
    input  logic            bit_stb,
    output logic [ID_W-1:0] id_out,
    output logic            id_valid,
    output logic            frame_err
);

    localparam int PAY_BITS = 2 * ID_W;
    localparam int CW       = $clog2(IDLE_BITS + PRE_BITS + 1);
    localparam int LW       = $clog2(RUN_MAX + 1);
    localparam int NW       = $clog2(PAY_BITS + 1);

    localparam logic [CW-1:0] IDLE_C = CW'(IDLE_BITS);
    localparam logic [CW-1:0] PRE_C  = CW'(PRE_BITS);
    localparam logic [CW-1:0] C_ONE  = CW'(1);
    localparam logic [NW-1:0] N_LAST = NW'(PAY_BITS - 1);
    localparam logic [NW-1:0] N_ONE  = NW'(1);

    typedef struct packed {
        rx_state_e         st;
        logic [CW-1:0]     cnt;
        logic              run_pol;
        logic [LW-1:0]     run_len;
        logic [PAY_BITS-1:0] sh;
        logic [NW-1:0]     nbits;
        logic [ID_W-1:0]   id;
        logic              valid;
        logic              err;
    } rx_regs_t;

    rx_regs_t q, d;

    logic          is_stuff, stuff_bad, nxt_pol;
    logic [LW-1:0] nxt_len;
    logic          inv_ok;
    logic [ID_W-1:0] id_cand;
    logic [PAY_BITS-1:0] word_now;

    assign word_now = {q.sh[PAY_BITS-2:0], rx_line};

    ook_destuff #(.RUN_MAX(RUN_MAX)) u_destuff (
        .run_pol  (q.run_pol),
        .run_len  (q.run_len),
        .bit_in   (rx_line),
        .is_stuff (is_stuff),
        .stuff_bad(stuff_bad),
        .nxt_pol  (nxt_pol),
        .nxt_len  (nxt_len)
    );

    ook_inv_check #(.ID_W(ID_W)) u_inv (
        .word   (word_now),
        .match  (inv_ok),
        .id_part(id_cand)
    );

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.err   = 1'b0;
        if (bit_stb) begin
            unique case (q.st)
                S_QUIET: begin
                    if (!rx_line) begin
                        if (q.cnt < IDLE_C) d.cnt = q.cnt + C_ONE;
                    end else if (q.cnt == IDLE_C) begin
                        d.st  = S_PDOM;
                        d.cnt = C_ONE;
                    end else begin
                        d.cnt = '0;
                    end
                end
                S_PDOM: begin
                    if (rx_line) begin
                        if (q.cnt == PRE_C) begin
                            d.st  = S_QUIET;
                            d.cnt = '0;
                        end else begin
                            d.cnt = q.cnt + C_ONE;
                        end
                    end else if (q.cnt == PRE_C) begin
                        d.st  = S_PREC;
                        d.cnt = C_ONE;
                    end else begin
                        d.st  = S_QUIET;
                        d.cnt = '0;
                    end
                end
                S_PREC: begin
                    if (!rx_line) begin
                        if (q.cnt == PRE_C) begin
                            d.st  = S_QUIET;
                            d.cnt = '0;
                        end else begin
                            d.cnt = q.cnt + C_ONE;
                        end
                    end else if (q.cnt == PRE_C) begin
                        d.st      = S_DATA;
                        d.run_pol = 1'b1;
                        d.run_len = LW'(1);
                        d.nbits   = '0;
                    end else begin
                        d.st  = S_QUIET;
                        d.cnt = '0;
                    end
                end
                S_DATA: begin
                    if (stuff_bad) begin
                        d.err = 1'b1;
                        d.st  = S_QUIET;
                        d.cnt = '0;
                    end else begin
                        d.run_pol = nxt_pol;
                        d.run_len = nxt_len;
                        if (!is_stuff) begin
                            d.sh    = word_now;
                            d.nbits = q.nbits + N_ONE;
                            if (q.nbits == N_LAST) begin
                                d.st  = S_QUIET;
                                d.cnt = '0;
                                if (inv_ok) begin
                                    d.id    = id_cand;
                                    d.valid = 1'b1;
                                end else begin
                                    d.err = 1'b1;
                                end
                            end
                        end
                    end
                end
                default: begin
                    d.st  = S_QUIET;
                    d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_QUIET, cnt: '0, run_pol: 1'b0, run_len: '0,
                   sh: '0, nbits: '0, id: '0, valid: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign id_out    = q.id;
    assign id_valid  = q.valid;
    assign frame_err = q.err;

    // R4: accept pulse lasts one clock
    a_r4_valid_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |=> !id_valid);

    // R7: a rejected frame never also reports an ID
    a_r7_no_valid_with_err: assert property (@(posedge clk) disable iff (!rst_n)
        !(id_valid && frame_err));

    // R8: ID output moves only together with the valid pulse
    a_r8_id_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (id_out != $past(id_out)) |-> id_valid);

    // R9: nothing moves after a cycle without a strobe
    a_r9_idle_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> ($stable(q.st) && !id_valid && !frame_err));

    // R5: run length stays within 1..RUN_MAX while collecting payload
    a_r5_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DATA) |-> (q.run_len != '0 && q.run_len <= LW'(RUN_MAX)));

    // R10: a finished frame leaves the receiver in quiet search with a cleared count
    a_r10_back_to_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid || frame_err) |-> (q.st == S_QUIET && q.cnt == '0));

endmodule

// File: tb/tb_ook_frame_rx.sv
module tb_ook_frame_rx;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b0;
    logic       bit_stb = 1'b0;
    logic [7:0] id_out;
    logic       id_valid;
    logic       frame_err;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit        is_err;
        logic [7:0] id;
        string     req;
    } exp_t;

    exp_t exp_q[$];
    logic [7:0] last_id = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    ook_frame_rx dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_line  (rx_line),
        .bit_stb  (bit_stb),
        .id_out   (id_out),
        .id_valid (id_valid),
        .frame_err(frame_err)
    );

    task automatic summary_and_finish();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    // R9: non-strobe cycles carry the inverted level as noise
    task automatic send_bit(logic b);
        @(negedge clk);
        rx_line = b;
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        rx_line = ~b;
        repeat (2) @(negedge clk);
    endtask

    // Full frame: quiet bits, preamble runs, start bit, stuffed payload, trailer.
    // bad_at > 0 sends the bad_at-th stuff bit at the wrong level and stops.
    task automatic send_frame(int idle_n, int pdom, int prec, logic [7:0] a,
                              logic [7:0] b, int bad_at, int trail_n,
                              int kind, string req);
        logic [15:0] word;
        logic        pol;
        int          len;
        int          stuffs;
        bit          aborted;
        exp_t        e;
        word = {a, b};
        if (kind != 0) begin
            e.is_err = (kind == 2);
            e.id     = a;
            e.req    = req;
            exp_q.push_back(e);
        end
        for (int i = 0; i < idle_n; i++) send_bit(1'b0);
        for (int i = 0; i < pdom; i++) send_bit(1'b1);
        for (int i = 0; i < prec; i++) send_bit(1'b0);
        send_bit(1'b1);
        pol = 1'b1;
        len = 1;
        stuffs = 0;
        aborted = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            if (!aborted) begin
                if (len == 4) begin
                    stuffs++;
                    if (stuffs == bad_at) begin
                        send_bit(pol);
                        aborted = 1'b1;
                    end else begin
                        send_bit(~pol);
                        pol = ~pol;
                        len = 1;
                    end
                end
                if (!aborted) begin
                    send_bit(word[i]);
                    if (word[i] == pol) len++;
                    else begin
                        pol = word[i];
                        len = 1;
                    end
                end
            end
        end
        for (int i = 0; i < trail_n; i++) send_bit(1'b0);
        repeat (4) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (id_valid || frame_err)) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2/R3 unexpected pulse: actual valid=%0b err=%0b expected none",
                         id_valid, frame_err);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(frame_err == e.is_err && id_valid == !e.is_err, e.req,
                      "pulse kind (1=err)", int'(frame_err), int'(e.is_err));
                if (!e.is_err) begin
                    check(id_out == e.id, e.req, "id_out", int'(id_out), int'(e.id));
                    last_id = e.id;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary_and_finish();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(id_out == 8'h00, "R1", "id_out in reset", int'(id_out), 0);
        check(!id_valid && !frame_err, "R1", "pulses in reset",
              int'({id_valid, frame_err}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(id_out == 8'h00 && !id_valid && !frame_err, "R1", "after reset release",
              int'({id_valid, frame_err, id_out}), 0);

        // R4: plain frames, no stuffing needed
        send_frame(7, 5, 5, 8'h55, 8'hAA, 0, 6, 1, "R4");
        send_frame(6, 5, 5, 8'hA5, 8'h5A, 0, 6, 1, "R4");
        // R5: long runs at both levels force stuff bits at several offsets
        send_frame(6, 5, 5, 8'hFF, 8'h00, 0, 6, 1, "R5");
        send_frame(6, 5, 5, 8'h00, 8'hFF, 0, 6, 1, "R5");
        send_frame(6, 5, 5, 8'hF0, 8'h0F, 0, 6, 1, "R5");
        send_frame(6, 5, 5, 8'h87, 8'h78, 0, 6, 1, "R5");

        // R2: only 5 quiet bits after a dominant bit
        send_bit(1'b1);
        send_frame(5, 5, 5, 8'h3C, 8'hC3, 0, 6, 0, "R2");
        check(exp_q.size() == 0 && id_out == last_id, "R2", "id after short quiet",
              int'(id_out), int'(last_id));

        // R3: wrong preamble lengths
        send_frame(6, 4, 5, 8'h3C, 8'hC3, 0, 6, 0, "R3");
        send_frame(6, 6, 5, 8'h3C, 8'hC3, 0, 6, 0, "R3");
        send_frame(6, 5, 4, 8'h3C, 8'hC3, 0, 6, 0, "R3");
        send_frame(6, 5, 6, 8'h3C, 8'hC3, 0, 6, 0, "R3");
        check(exp_q.size() == 0 && id_out == last_id, "R3", "id after bad preambles",
              int'(id_out), int'(last_id));

        // R6: wrong-level stuff bit at first and later stuff positions
        send_frame(6, 5, 5, 8'hFF, 8'h00, 1, 7, 2, "R6");
        send_frame(6, 5, 5, 8'hFF, 8'h00, 3, 7, 2, "R6");
        check(id_out == last_id, "R6", "id after stuff error", int'(id_out), int'(last_id));

        // R7: inverse mismatch
        send_frame(6, 5, 5, 8'h3C, 8'h3D, 0, 6, 2, "R7");
        send_frame(6, 5, 5, 8'h12, 8'h12, 0, 6, 2, "R7");
        // R8: id held through rejected frames
        check(id_out == last_id, "R8", "id after inverse failures", int'(id_out), int'(last_id));

        // R10: good frame with short trailer, then a frame with no fresh quiet run
        send_frame(6, 5, 5, 8'hC6, 8'h39, 0, 3, 1, "R10");
        send_frame(0, 5, 5, 8'h21, 8'hDE, 0, 6, 0, "R10");
        check(exp_q.size() == 0 && id_out == 8'hC6, "R10", "frame without fresh quiet",
              int'(id_out), 'hC6);
        send_frame(6, 5, 5, 8'h21, 8'hDE, 0, 6, 1, "R10");

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
        summary_and_finish();
    end

endmodule